// File: doc/BRIEF.md
# Dual-Scheme LED Blink Controller

This block drives eight open-drain LED pins. Every pin has a two-bit mode: released (LED dark), held low (LED lit), or flashing under one of two shared blink schemes. Each scheme has its own prescaler and its own duty value, so one group of pins can flash slowly while another flashes fast. The two schemes run independently of each other.

A scheme counts ticks of a slow time base. The time base is a `tick` strobe that stands in for an on-chip oscillator running at 256 times the fastest blink rate. A prescaler value P stretches each step of an 8-bit phase counter to P+1 ticks. One blink period is therefore 256·(P+1) ticks, which gives about 38 Hz down to about 0.148 Hz. A pin in blink mode is pulled low while the phase is below the duty value.

The pad levels are synchronised and can be read back at register address 0. A pin that is left released can therefore act as a general-purpose input. Software reaches the registers through a plain single-cycle write port and a combinational read port. Address map: 0 pin levels, 1 prescaler A, 2 duty A, 3 prescaler B, 4 duty B, 5 selector for pins 0–3, 6 selector for pins 4–7. The active-low reset clears every register.

Top module: `led_blink_ctrl`

## Requirements
- R1: While reset is low, and directly after it, every register reads 0 and no pin is driven (`led_drive` is all zero).
- R2: Selector code 2'b00 releases a pin (`led_drive` bit 0). Code 2'b01 pulls the pin low (`led_drive` bit 1). Both take effect in the cycle after the write.
- R3: A pin in blink mode is driven for exactly `duty` of every 256 phase steps. Duty 0 never drives the pin, and duty 255 drives it for 255 of the 256 steps.
- R4: One blink period lasts (prescaler+1)·256 tick pulses, and the phase advances by one every prescaler+1 ticks.
- R5: A write to a scheme's prescaler register resets that scheme's prescale and phase counters to zero at that clock edge. Its blink output therefore starts a fresh period with the active part first.
- R6: Code 2'b11 selects scheme B and code 2'b10 selects scheme A. The two schemes keep separate settings and counters.
- R7: Pin n takes its code from register 5 when n<4 and from register 6 otherwise, in bits [2(n mod 4)+1 : 2(n mod 4)].
- R8: Address 0 returns the pad levels two clock edges after they change. A write to address 0 has no effect.
- R9: Registers 1 to 6 read back the last value written to them.
- R10: While `tick` is low, the blink counters hold, so a blinking pin keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one pulse per base tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| pin_level | input | 8 | Sensed level of each pad |
| led_drive | output | 8 | 1 = pull pad low (LED lit), 0 = release |

## Verification
The bench uses the default build: eight pins, 8-bit registers and a two-stage input synchroniser. It holds `tick` high so that the phase steps once per clock. With prescaler values 0 and 2, a full blink period takes 256 or 768 cycles, short enough to count the active cycles exactly over whole periods. These values also let the bench watch the first phase boundary after a prescaler write, and check that both schemes run with different duty values at the same time.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
   typedef enum logic [1:0] {
      LED_OFF    = 2'b00,
      LED_ON     = 2'b01,
      LED_BLINK0 = 2'b10,
      LED_BLINK1 = 2'b11
   } led_mode_e;

   localparam int unsigned ADDR_PINS     = 0;
   localparam int unsigned ADDR_PSC0     = 1;
   localparam int unsigned ADDR_DUTY0    = 2;
   localparam int unsigned ADDR_PSC1     = 3;
   localparam int unsigned ADDR_DUTY1    = 4;
   localparam int unsigned ADDR_SEL_BASE = 5;
   localparam int unsigned NUM_SCHEMES   = 2;
endpackage

// File: rtl/led_pin_sync.sv
module led_pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("led_pin_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < int'(STAGES); s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
   parameter int unsigned PSC_W = 8,
   parameter int unsigned PH_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [PSC_W-1:0] psc,
   input  logic [PH_W-1:0]  duty,
   output logic [PH_W-1:0]  phase,
   output logic             active
);
   logic [PSC_W-1:0] pre_q;
   logic [PH_W-1:0]  phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q   <= '0;
         phase_q <= '0;
      end else if (restart) begin
         pre_q   <= '0;
         phase_q <= '0;
      end else if (tick) begin
         if (pre_q == psc) begin
            pre_q   <= '0;
            phase_q <= phase_q + 1'b1;
         end else begin
            pre_q   <= pre_q + 1'b1;
         end
      end
   end

   assign phase  = phase_q;
   assign active = (phase_q < duty);
endmodule

// File: rtl/led_blink_regs.sv
module led_blink_regs
   import led_blink_pkg::*;
#(
   parameter int unsigned NUM_OUT = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned PSC_W   = 8,
   parameter int unsigned PH_W    = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [DATA_W-1:0]                   wr_data,
   input  logic [NUM_OUT-1:0]                  pins_sync,
   output logic [DATA_W-1:0]                   rd_data,
   output logic [NUM_SCHEMES-1:0][PSC_W-1:0]   psc,
   output logic [NUM_SCHEMES-1:0][PH_W-1:0]    duty,
   output logic [NUM_SCHEMES-1:0]              restart,
   output logic [2*NUM_OUT-1:0]                mode_flat
);
   localparam int unsigned PER_REG = DATA_W / 2;
   localparam int unsigned NUM_SEL = (NUM_OUT + PER_REG - 1) / PER_REG;

   logic [NUM_SCHEMES-1:0][PSC_W-1:0] psc_q;
   logic [NUM_SCHEMES-1:0][PH_W-1:0]  duty_q;
   logic [NUM_SEL-1:0][DATA_W-1:0]    sel_q;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned target);
      return a == ADDR_W'(target);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q  <= '0;
         duty_q <= '0;
         sel_q  <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < int'(NUM_SCHEMES); k++) begin
            if (hit(addr, ADDR_PSC0 + 2*k)) psc_q[k]  <= wr_data[PSC_W-1:0];
            if (hit(addr, ADDR_DUTY0 + 2*k)) duty_q[k] <= wr_data[PH_W-1:0];
         end
         for (int s = 0; s < int'(NUM_SEL); s++) begin
            if (hit(addr, ADDR_SEL_BASE + s)) sel_q[s] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (hit(addr, ADDR_PINS)) rd_data[NUM_OUT-1:0] = pins_sync;
      for (int k = 0; k < int'(NUM_SCHEMES); k++) begin
         if (hit(addr, ADDR_PSC0 + 2*k))  rd_data[PSC_W-1:0] = psc_q[k];
         if (hit(addr, ADDR_DUTY0 + 2*k)) rd_data[PH_W-1:0]  = duty_q[k];
      end
      for (int s = 0; s < int'(NUM_SEL); s++) begin
         if (hit(addr, ADDR_SEL_BASE + s)) rd_data = sel_q[s];
      end
   end

   genvar n, k;
   generate
      for (k = 0; k < NUM_SCHEMES; k++) begin : g_restart
         assign restart[k] = wr_en && hit(addr, ADDR_PSC0 + 2*k);
      end
      for (n = 0; n < NUM_OUT; n++) begin : g_mode
         assign mode_flat[2*n +: 2] = sel_q[n / PER_REG][2*(n % PER_REG) +: 2];
      end
   endgenerate

   assign psc  = psc_q;
   assign duty = duty_q;
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
   import led_blink_pkg::*;
#(
   parameter int unsigned NUM_OUT     = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned PSC_W       = 8,
   parameter int unsigned PH_W        = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_OUT-1:0] pin_level,
   output logic [NUM_OUT-1:0] led_drive
);
   localparam int unsigned NUM_SEL = (2 * NUM_OUT + DATA_W - 1) / DATA_W;
   localparam int unsigned LAST_ADDR = ADDR_SEL_BASE + NUM_SEL - 1;

   generate
      if (DATA_W != 8) begin : g_chk_data
         $error("led_blink_ctrl: DATA_W must be 8");
      end
      if (NUM_OUT > DATA_W || NUM_OUT < 1) begin : g_chk_out
         $error("led_blink_ctrl: NUM_OUT must be 1..DATA_W");
      end
      if (PSC_W > DATA_W || PH_W > DATA_W) begin : g_chk_w
         $error("led_blink_ctrl: PSC_W and PH_W must not exceed DATA_W");
      end
      if (LAST_ADDR >= (1 << ADDR_W)) begin : g_chk_addr
         $error("led_blink_ctrl: ADDR_W too small for register map");
      end
   endgenerate

   logic [NUM_OUT-1:0]                pins_sync;
   logic [NUM_SCHEMES-1:0][PSC_W-1:0] psc;
   logic [NUM_SCHEMES-1:0][PH_W-1:0]  duty;
   logic [NUM_SCHEMES-1:0]            restart;
   logic [2*NUM_OUT-1:0]              mode_flat;
   logic [NUM_SCHEMES-1:0]            sch_active;
   logic [NUM_SCHEMES-1:0][PH_W-1:0]  sch_phase;

   led_pin_sync #(.WIDTH(NUM_OUT), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_level),
      .dout (pins_sync)
   );

   led_blink_regs #(
      .NUM_OUT(NUM_OUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .PSC_W(PSC_W), .PH_W(PH_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .pins_sync(pins_sync),
      .rd_data  (rd_data),
      .psc      (psc),
      .duty     (duty),
      .restart  (restart),
      .mode_flat(mode_flat)
   );

   genvar k, n;
   generate
      for (k = 0; k < NUM_SCHEMES; k++) begin : g_scheme
         led_blink_gen #(.PSC_W(PSC_W), .PH_W(PH_W)) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .restart(restart[k]),
            .psc    (psc[k]),
            .duty   (duty[k]),
            .phase  (sch_phase[k]),
            .active (sch_active[k])
         );
      end

      for (n = 0; n < NUM_OUT; n++) begin : g_pin
         led_mode_e mode;
         assign mode = led_mode_e'(mode_flat[2*n +: 2]);
         always_comb begin
            unique case (mode)
               LED_OFF:    led_drive[n] = 1'b0;
               LED_ON:     led_drive[n] = 1'b1;
               LED_BLINK0: led_drive[n] = sch_active[0];
               LED_BLINK1: led_drive[n] = sch_active[1];
               default:    led_drive[n] = 1'b0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/led_blink_ctrl_chk.sv
module led_blink_ctrl_chk #(
   parameter int unsigned NUM_OUT = 8,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned PH_W    = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [1:0]         sel0,
   input logic [NUM_OUT-1:0] led_drive,
   input logic [PH_W-1:0]    phase0,
   input logic [PH_W-1:0]    phase1
);
   logic psc0_wr, psc1_wr, sel_wr;
   assign psc0_wr = wr_en && (addr == ADDR_W'(1));
   assign psc1_wr = wr_en && (addr == ADDR_W'(3));
   assign sel_wr  = wr_en && (addr == ADDR_W'(5));

   a_r1_reset_released: assert property (@(posedge clk)
      !rst_n |-> (led_drive == '0));

   a_r2_on_code: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && sel0 == 2'b01) |=> led_drive[0]);

   a_r2_off_code: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && sel0 == 2'b00) |=> !led_drive[0]);

   a_r5_restart_a: assert property (@(posedge clk) disable iff (!rst_n)
      psc0_wr |=> (phase0 == '0));

   a_r5_restart_b: assert property (@(posedge clk) disable iff (!rst_n)
      psc1_wr |=> (phase1 == '0));

   a_r10_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !psc0_wr) |=> $stable(phase0));

   a_r10_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !psc1_wr) |=> $stable(phase1));

   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !psc0_wr) |=>
         (phase0 == $past(phase0) || phase0 == PH_W'($past(phase0) + 1'b1)));
endmodule

bind led_blink_ctrl led_blink_ctrl_chk #(
   .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .PH_W(PH_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_en    (wr_en),
   .addr     (addr),
   .sel0     (wr_data[1:0]),
   .led_drive(led_drive),
   .phase0   (sch_phase[0]),
   .phase1   (sch_phase[1])
);

// File: tb/led_blink_ctrl_bench.sv
module led_blink_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] pin_level = '0;
   logic [7:0] led_drive;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   led_blink_ctrl u_led_blink_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .pin_level(pin_level),
      .led_drive(led_drive)
   );

   task automatic check(input string req, input int actual, input int expected);
      n_tests++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic write_reg(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_reg(input int a, output int d);
      addr = 3'(a);
      #1;
      d = int'(rd_data);
   endtask

   // Samples led_drive[idx] on n consecutive negedges, starting with the current one.
   task automatic count_on(input int idx, input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         cnt += int'(led_drive[idx]);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      int v;
      check("R1 drive after reset", int'(led_drive), 0);
      for (int a = 1; a <= 6; a++) begin
         read_reg(a, v);
         check("R1 register after reset", v, 0);
      end
   endtask

   task automatic t_readback();
      int v;
      int vals[6] = '{8'h3C, 8'hA5, 8'h01, 8'hFE, 8'h00, 8'h00};
      for (int a = 1; a <= 4; a++) write_reg(a, vals[a-1]);
      for (int a = 1; a <= 4; a++) begin
         read_reg(a, v);
         check("R9 readback", v, vals[a-1]);
      end
   endtask

   task automatic t_static_modes();
      write_reg(5, 8'b0000_0100);
      check("R2 R7 pin1 on", int'(led_drive), 8'b0000_0010);
      write_reg(5, 8'b0000_0000);
      check("R2 pin1 off", int'(led_drive), 0);
      write_reg(6, 8'b0100_0000);
      check("R7 pin7 on via reg 6", int'(led_drive), 8'b1000_0000);
      write_reg(6, 8'b0000_0001);
      check("R7 pin4 on via reg 6", int'(led_drive), 8'b0001_0000);
      write_reg(6, 8'h00);
   endtask

   task automatic t_duty(input int duty);
      int cnt;
      tick = 1'b1;
      write_reg(2, duty);
      write_reg(5, 8'hAA);
      write_reg(1, 0);
      count_on(2, 256, cnt);
      check($sformatf("R3 duty %0d", duty), cnt, duty);
   endtask

   task automatic t_period();
      int c1, c2;
      tick = 1'b1;
      write_reg(2, 128);
      write_reg(5, 8'h02);
      write_reg(1, 2);
      check("R5 active at period start", int'(led_drive[0]), 1);
      count_on(0, 384, c1);
      check("R4 active span", c1, 384);
      count_on(0, 384, c2);
      check("R4 inactive span", c2, 0);
      check("R4 next period", int'(led_drive[0]), 1);
   endtask

   task automatic t_two_schemes();
      int ca, cb;
      tick = 1'b1;
      write_reg(2, 32);
      write_reg(4, 192);
      write_reg(5, 8'hAA);
      write_reg(6, 8'hFF);
      write_reg(3, 0);
      count_on(5, 256, cb);
      check("R6 scheme B duty", cb, 192);
      write_reg(1, 0);
      count_on(1, 256, ca);
      check("R6 scheme A duty", ca, 32);
      check("R6 pins 4-7 same scheme", int'(led_drive[7:4] == {4{led_drive[4]}}), 1);
   endtask

   task automatic t_hold();
      int cnt;
      tick = 1'b1;
      write_reg(2, 128);
      write_reg(5, 8'h02);
      tick = 1'b0;
      write_reg(1, 0);
      count_on(0, 300, cnt);
      check("R10 hold without tick", cnt, 300);
      tick = 1'b1;
      count_on(0, 128, cnt);
      check("R10 resumes with tick", int'(led_drive[0]), 0);
   endtask

   task automatic t_inputs();
      int v;
      write_reg(5, 8'h00);
      write_reg(6, 8'h00);
      @(negedge clk);
      pin_level = 8'h5A;
      @(negedge clk);
      read_reg(0, v);
      check("R8 one edge not yet visible", v, 0);
      @(negedge clk);
      read_reg(0, v);
      check("R8 pin levels", v, 8'h5A);
      write_reg(0, 8'hFF);
      read_reg(0, v);
      check("R8 write to pins ignored", v, 8'h5A);
      check("R8 write to pins no drive", int'(led_drive), 0);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 drive in reset", int'(led_drive), 0);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_static_modes();
      t_duty(64);
      t_duty(0);
      t_duty(255);
      t_period();
      t_two_schemes();
      t_hold();
      t_inputs();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule